// File: doc/BRIEF.md
# SIMD Floating-Point Control and Status Register

This block is the 32-bit control and status word of a SIMD floating-point unit. It holds six sticky exception flags and a mask bit for each of them. It also holds a two-bit rounding-mode field, a flush-to-zero enable and a denormal-inputs-as-zero enable. Software loads the word through a write port and reads it back through a read port. The control fields go straight out to the datapath.

Each cycle the execution side may report which exception conditions an operation detected. Those conditions are ORed into the sticky flags. A one-cycle exception request is raised when any detected condition is not masked. Loads that put a non-zero value into the upper sixteen reserved bits are rejected: the register keeps its old contents and a protection-fault pulse is raised. A load on its own never causes an exception request, even when it unmasks a condition whose flag is already set. Only a later operation that detects that condition raises the request.

Top module: `fp_simd_csr`

## Requirements
- R1: During and after reset the register reads 0x00001F80. The six flags are clear, bit 6 (denormals-as-zero) is clear, the six masks in bits 7..12 are set, the rounding field in bits 13..14 is 00, bit 15 (flush-to-zero) is clear, and bits 16..31 are zero. `excReq` and `protFault` are low.
- R2: When `opValid` is high at a clock edge, each set bit of `opExc` sets the flag at the same index. Index order is 0 invalid, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow, 5 precision. The flag reads back after that edge. `opExc` has no effect while `opValid` is low.
- R3: A set flag stays set across all later cycles until an accepted load writes a zero to it.
- R4: A load with bits 31..16 all zero replaces the whole register at the clock edge. The new value is visible on `rdData` after that edge.
- R5: A load with any non-zero bit in 31..16 is rejected. The register keeps its previous value, apart from same-cycle detections. `protFault` is high for exactly the cycle after that edge. Bits 31..16 always read zero.
- R6: `excReq` is high for the one cycle after an edge where `opValid` was high and `opExc & ~mask` was non-zero. Here `mask[i]` is register bit 7+i.
- R7: A load that clears a mask bit while the matching flag is set raises no `excReq`, unless a detection in that same cycle is itself unmasked.
- R8: When an accepted load and a detection share a cycle, the loaded value is applied first and the detections are then ORed into its flags. The unmask test of R6 uses the masks from the loaded value.
- R9: `roundMode` equals register bits 14..13, `flushZero` equals bit 15 and `denormZero` equals bit 6, at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Software load strobe |
| wrData | input | 32 | Value to load |
| rdData | output | 32 | Current register contents |
| opValid | input | 1 | An operation reports detected conditions this cycle |
| opExc | input | 6 | Detected exception conditions, flag order |
| excReq | output | 1 | One-cycle exception request pulse |
| protFault | output | 1 | One-cycle fault pulse for a rejected load |
| roundMode | output | 2 | Rounding-mode field to the datapath |
| flushZero | output | 1 | Flush-to-zero enable |
| denormZero | output | 1 | Denormal-inputs-as-zero enable |

## Verification
Every result of a stimulus applied before a clock edge is due right after that edge. This covers the register contents on `rdData`, the control exports, and both the `excReq` and `protFault` pulses. The bench drives inputs on the falling edge and updates its own model of the word for that edge. It then samples all outputs one nanosecond after the next rising edge, so each check lands in the single cycle where a pulse must be high or low. Directed steps cover sticky flags, unmasking a set flag, rejected loads and loads that coincide with detections. A long seeded random run follows.

// File: rtl/fp_simd_csr_pkg.sv
package fp_simd_csr_pkg;
  localparam int CSR_W   = 32;
  localparam int EXC_N   = 6;
  localparam int DAZ_BIT = EXC_N;
  localparam int MASK_LO = DAZ_BIT + 1;
  localparam int RC_LO   = MASK_LO + EXC_N;
  localparam int RC_W    = 2;
  localparam int FTZ_BIT = RC_LO + RC_W;
  localparam int RSV_LO  = FTZ_BIT + 1;
  localparam logic [CSR_W-1:0] RESET_VAL =
    CSR_W'(((1 << EXC_N) - 1) << MASK_LO);

  typedef struct packed {
    logic loadOk;
    logic detect;
  } csrStrobe_t;
endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import fp_simd_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CSR_W-1:0] wrData,
  input  logic             opValid,
  input  logic             unmaskedHit,
  output csrStrobe_t       strobe,
  output logic             excReq,
  output logic             protFault
);
  logic reservedBad;

  assign reservedBad   = |wrData[CSR_W-1:RSV_LO];
  assign strobe.loadOk = wrEn & ~reservedBad;
  assign strobe.detect = opValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excReq    <= 1'b0;
      protFault <= 1'b0;
    end else begin
      excReq    <= unmaskedHit;
      protFault <= wrEn & reservedBad;
    end
  end
endmodule

// File: rtl/csr_datapath.sv
module csr_datapath
  import fp_simd_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  csrStrobe_t       strobe,
  input  logic [CSR_W-1:0] wrData,
  input  logic [EXC_N-1:0] opExc,
  output logic [CSR_W-1:0] csrQ,
  output logic             unmaskedHit
);
  logic [CSR_W-1:0] baseVal;
  logic [CSR_W-1:0] csrNext;
  logic [EXC_N-1:0] hitVec;

  assign baseVal = strobe.loadOk ? wrData : csrQ;

  genvar i;
  generate
    for (i = 0; i < EXC_N; i++) begin : g_flag
      assign csrNext[i] = baseVal[i] | (strobe.detect & opExc[i]);
      assign hitVec[i]  = strobe.detect & opExc[i] & ~baseVal[MASK_LO+i];
    end
  endgenerate

  assign csrNext[RSV_LO-1:EXC_N] = baseVal[RSV_LO-1:EXC_N];
  assign csrNext[CSR_W-1:RSV_LO] = '0;
  assign unmaskedHit = |hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csrQ <= RESET_VAL;
    else       csrQ <= csrNext;
  end
endmodule

// File: rtl/fp_simd_csr.sv
module fp_simd_csr
  import fp_simd_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CSR_W-1:0] wrData,
  output logic [CSR_W-1:0] rdData,
  input  logic             opValid,
  input  logic [EXC_N-1:0] opExc,
  output logic             excReq,
  output logic             protFault,
  output logic [RC_W-1:0]  roundMode,
  output logic             flushZero,
  output logic             denormZero
);
  csrStrobe_t       strobe;
  logic [CSR_W-1:0] csrQ;
  logic             unmaskedHit;

  csr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .opValid(opValid), .unmaskedHit(unmaskedHit), .strobe(strobe),
    .excReq(excReq), .protFault(protFault)
  );

  csr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .opExc(opExc), .csrQ(csrQ), .unmaskedHit(unmaskedHit)
  );

  assign rdData     = csrQ;
  assign roundMode  = csrQ[RC_LO +: RC_W];
  assign flushZero  = csrQ[FTZ_BIT];
  assign denormZero = csrQ[DAZ_BIT];
endmodule

// File: rtl/fp_simd_csr_chk.sv
module fp_simd_csr_chk
  import fp_simd_csr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [CSR_W-1:0] wrData,
  input logic [CSR_W-1:0] rdData,
  input logic             opValid,
  input logic [EXC_N-1:0] opExc,
  input logic             excReq,
  input logic             protFault
);
  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdData[CSR_W-1:RSV_LO] == '0);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> (($past(rdData[EXC_N-1:0]) & ~rdData[EXC_N-1:0]) == '0));

  assert_fault_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> ($past(wrEn) && ($past(wrData[CSR_W-1:RSV_LO]) != '0)));

  assert_fault_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (protFault && !$past(opValid)) |-> $stable(rdData));

  assert_exc_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (($past(opExc) & ~rdData[MASK_LO +: EXC_N]) != '0));

  assert_exc_needs_op_R7: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> $past(opValid));
endmodule

bind fp_simd_csr fp_simd_csr_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .opValid(opValid), .opExc(opExc), .excReq(excReq), .protFault(protFault)
);

// File: tb/sim_fp_simd_csr.sv
`timescale 1ns/1ps
module sim_fp_simd_csr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        opValid = 1'b0;
  logic [5:0]  opExc = '0;
  logic        excReq, protFault, flushZero, denormZero;
  logic [1:0]  roundMode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] model = 32'h0000_1F80;

  always #2.5 clk = ~clk;

  fp_simd_csr u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .opValid(opValid), .opExc(opExc), .excReq(excReq), .protFault(protFault),
    .roundMode(roundMode), .flushZero(flushZero), .denormZero(denormZero)
  );

  function automatic logic [31:0] baseOf(logic wr, logic [31:0] d, logic [31:0] cur);
    return (wr && d[31:16] == 16'd0) ? d : cur;
  endfunction

  function automatic logic [31:0] nextOf(logic wr, logic [31:0] d, logic opv,
                                         logic [5:0] ex, logic [31:0] cur);
    logic [31:0] b = baseOf(wr, d, cur);
    if (opv) b[5:0] = b[5:0] | ex;
    return b;
  endfunction

  function automatic logic excOf(logic wr, logic [31:0] d, logic opv,
                                 logic [5:0] ex, logic [31:0] cur);
    logic [31:0] b = baseOf(wr, d, cur);
    return opv && ((ex & ~b[12:7]) != 6'd0);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [31:0] d, input logic opv,
                      input logic [5:0] ex, input string tag);
    logic expExc   = excOf(wr, d, opv, ex, model);
    logic expFault = wr && (d[31:16] != 16'd0);
    wrEn = wr; wrData = d; opValid = opv; opExc = ex;
    model = nextOf(wr, d, opv, ex, model);
    @(posedge clk);
    #1;
    check(tag, "rdData", rdData, model);
    check(tag, "excReq", {31'd0, excReq}, {31'd0, expExc});
    check(tag, "protFault", {31'd0, protFault}, {31'd0, expFault});
    check("R9", "exports", {28'd0, roundMode, flushZero, denormZero},
          {28'd0, model[14:13], model[15], model[6]});
    @(negedge clk);
    wrEn = 1'b0; opValid = 1'b0;
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'hC5A1);
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset rdData", rdData, 32'h0000_1F80);
    check("R1", "reset pulses", {30'd0, excReq, protFault}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1", "after release", rdData, 32'h0000_1F80);
    check("R9", "reset exports", {28'd0, roundMode, flushZero, denormZero}, 32'd0);

    step(1'b0, 32'd0, 1'b1, 6'b000001, "R2");
    step(1'b0, 32'd0, 1'b0, 6'b111110, "R2");
    step(1'b0, 32'd0, 1'b1, 6'b100000, "R3");
    step(1'b0, 32'd0, 1'b0, 6'b000000, "R3");
    step(1'b1, 32'h0000_1F80, 1'b0, 6'b0, "R4");
    step(1'b0, 32'd0, 1'b1, 6'b000010, "R2");
    step(1'b1, 32'h0000_1E82, 1'b0, 6'b0, "R7");
    step(1'b0, 32'd0, 1'b0, 6'b0, "R7");
    step(1'b0, 32'd0, 1'b1, 6'b000010, "R6");
    step(1'b0, 32'd0, 1'b1, 6'b000001, "R6");
    step(1'b1, 32'h0001_0000, 1'b0, 6'b0, "R5");
    step(1'b1, 32'hFFFF_0000, 1'b1, 6'b000100, "R5");
    step(1'b1, 32'h0000_1B80, 1'b1, 6'b001000, "R8");
    step(1'b1, 32'h0000_FFC0, 1'b0, 6'b0, "R9");
    step(1'b1, 32'h0000_3F80, 1'b1, 6'b010000, "R8");

    for (int n = 0; n < 3000; n++) begin
      logic        wr  = ($urandom % 4) == 0;
      logic [31:0] d   = {16'd0, 16'($urandom)};
      logic        opv = ($urandom % 3) != 0;
      logic [5:0]  ex  = 6'($urandom) & 6'($urandom);
      if (($urandom % 4) == 0) d[31:16] = 16'($urandom) | 16'h0001;
      step(wr, d, opv, ex, (wr && d[31:16] != 0) ? "R5" : "R6");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule